// File: doc/BRIEF.md
# Missed-Burst Time-Out Monitor

This block watches a framed half-duplex link from the receiving side. On every frame boundary it asks whether the far end's burst was demodulated during that frame. It keeps a count of back-to-back frames that went by with nothing received. Once that run of silent frames reaches a limit set by the integrator, the block declares a time-out. While the time-out lasts, it pulls the valid-data indication low.

A single good burst ends the time-out at once. It restarts the count and lets valid-data rise again. The counter does not care whether the surrounding transceiver is powered up or down. A powered-down unit can therefore still lose its far end and report it.

The valid-data indication stays low after reset until the first burst arrives.

Top module: `burst_loss_monitor`

## Requirements
- R1: On a clock where `frame_tick` is high and `burst_ok` is low, the silent-frame count rises by exactly one. The new value is in effect from the following clock. Clocks with neither input high leave the count unchanged.
- R2: On a clock where `burst_ok` is high, the count returns to zero from the next clock. This holds even when `frame_tick` is high on the same clock.
- R3: The count stops at its top value, 15 for the default 4-bit counter, and does not wrap back to zero when further silent frames arrive.
- R4: `timed_out` is high whenever `limit` is nonzero and the count is at or above `limit`, read as an unsigned 4-bit number. It follows a change of `limit` without waiting for a clock.
- R5: A `limit` of zero switches time-out off, so `timed_out` stays low however many silent frames pass.
- R6: `data_valid` is high only when at least one burst has been received since reset and `timed_out` is low. A time-out therefore always forces it low.
- R7: `pwr_dn` has no effect on the count, on `timed_out` or on `data_valid`. Time-out builds up in both power states.
- R8: An active-low `rst_n` clears the count to zero and forgets any earlier burst. `timed_out` and `data_valid` are low from the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_tick | input | 1 | One-clock strobe marking the end of a frame |
| burst_ok | input | 1 | One-clock pulse: a far-end burst was demodulated |
| pwr_dn | input | 1 | Power-down level of the host transceiver (no effect here) |
| limit | input | 4 | Number of silent frames that trigger time-out; 0 disables |
| timed_out | output | 1 | Time-out state |
| data_valid | output | 1 | Valid-data indication, forced low during time-out |

## Verification
The count is not a port. The bench reads it out by sweeping `limit` from 1 to 15 between clock edges and watching where `timed_out` switches. This probe separates a wrapping counter from a saturating one after twenty silent frames.

The stimulus includes runs of silent frames ending exactly at the limit and one short of it. It includes a burst arriving together with a frame tick, which tells apart burst-first and tick-first priority. It also includes sparse bursts that keep resetting the count before it gets far.

Further patterns repeat silent runs with `pwr_dn` held at each level, to show power state is ignored. They also use a zero limit, and a reset in the middle of a time-out.

// File: rtl/blm_pkg.sv
package blm_pkg;
   localparam int unsigned BLM_CNT_W_DEF   = 4;
   localparam int unsigned BLM_LIMIT_W_DEF = 4;

   // next value of a saturating up-counter
   function automatic logic [31:0] blm_sat_next(input logic [31:0] cur, input logic [31:0] top);
      return (cur >= top) ? top : cur + 32'd1;
   endfunction
endpackage

// File: rtl/blm_miss_counter.sv
module blm_miss_counter #(
   parameter int unsigned CNT_W = blm_pkg::BLM_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hit,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_d;

   always_comb begin
      count_d = count_q;
      if (hit) begin
         count_d = '0;                       // a received burst wins over the tick
      end else if (tick) begin
         count_d = CNT_W'(blm_pkg::blm_sat_next(32'(count_q), 32'(CNT_TOP)));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         count_q <= count_d;
      end
   end

   assign count = count_q;
endmodule

// File: rtl/blm_limit_cmp.sv
module blm_limit_cmp #(
   parameter int unsigned CNT_W   = blm_pkg::BLM_CNT_W_DEF,
   parameter int unsigned LIMIT_W = blm_pkg::BLM_LIMIT_W_DEF
) (
   input  logic [CNT_W-1:0]   count,
   input  logic [LIMIT_W-1:0] limit,
   output logic               expire
);
   logic [CNT_W-1:0] lim_ext;
   logic             lim_on;

   generate
      if (CNT_W > LIMIT_W) begin : g_widen
         assign lim_ext = {{(CNT_W-LIMIT_W){1'b0}}, limit};
      end else begin : g_same
         assign lim_ext = limit;
      end
   endgenerate

   assign lim_on = |limit;
   assign expire = lim_on && (count >= lim_ext);
endmodule

// File: rtl/blm_valid_gate.sv
module blm_valid_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic expire,
   output logic valid
);
   logic seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
      end else if (hit) begin
         seen_q <= 1'b1;
      end
   end

   assign valid = seen_q && !expire;
endmodule

// File: rtl/burst_loss_monitor.sv
module burst_loss_monitor #(
   parameter int unsigned CNT_W   = blm_pkg::BLM_CNT_W_DEF,
   parameter int unsigned LIMIT_W = blm_pkg::BLM_LIMIT_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_tick,
   input  logic               burst_ok,
   input  logic               pwr_dn,
   input  logic [LIMIT_W-1:0] limit,
   output logic               timed_out,
   output logic               data_valid
);
   generate
      if (CNT_W < LIMIT_W) begin : g_bad_width
         $error("burst_loss_monitor: CNT_W must be at least LIMIT_W");
      end
      if (LIMIT_W < 1) begin : g_bad_limit
         $error("burst_loss_monitor: LIMIT_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] miss_cnt;
   logic             expire;
   logic             unused_pwr;

   // power state deliberately plays no part in the time-out decision
   assign unused_pwr = pwr_dn;

   blm_miss_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (frame_tick),
      .hit   (burst_ok),
      .count (miss_cnt)
   );

   blm_limit_cmp #(.CNT_W(CNT_W), .LIMIT_W(LIMIT_W)) i_cmp (
      .count  (miss_cnt),
      .limit  (limit),
      .expire (expire)
   );

   blm_valid_gate i_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (burst_ok),
      .expire (expire),
      .valid  (data_valid)
   );

   assign timed_out = expire;
endmodule

// File: rtl/blm_checker.sv
module blm_checker #(
   parameter int unsigned CNT_W   = blm_pkg::BLM_CNT_W_DEF,
   parameter int unsigned LIMIT_W = blm_pkg::BLM_LIMIT_W_DEF
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_tick,
   input logic               burst_ok,
   input logic [LIMIT_W-1:0] limit,
   input logic               timed_out,
   input logic               data_valid,
   input logic [CNT_W-1:0]   miss_cnt
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !burst_ok && miss_cnt != TOP) |=> (miss_cnt == $past(miss_cnt) + 1'b1)); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_tick && !burst_ok) |=> $stable(miss_cnt)); // R1
   AST_BURST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      burst_ok |=> (miss_cnt == '0)); // R2
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_cnt == TOP && !burst_ok) |=> (miss_cnt == TOP)); // R3
   AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0) |-> !timed_out); // R5
   AST_VALID_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      timed_out |-> !data_valid); // R6
   AST_BURST_REVIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_ok && !$past(!rst_n)) |=> (!timed_out && data_valid)); // R6
endmodule

bind burst_loss_monitor blm_checker #(.CNT_W(CNT_W), .LIMIT_W(LIMIT_W)) i_blm_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_tick (frame_tick),
   .burst_ok   (burst_ok),
   .limit      (limit),
   .timed_out  (timed_out),
   .data_valid (data_valid),
   .miss_cnt   (miss_cnt)
);

// File: tb/test_burst_loss_monitor.sv
`timescale 1ns/1ps
module test_burst_loss_monitor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_tick = 1'b0;
   logic       burst_ok = 1'b0;
   logic       pwr_dn = 1'b0;
   logic [3:0] limit = 4'd0;
   logic       timed_out;
   logic       data_valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int  m_cnt = 0;
   bit  m_seen = 0;

   always #2.5 clk = ~clk;

   burst_loss_monitor i_burst_loss_monitor (
      .clk, .rst_n, .frame_tick, .burst_ok, .pwr_dn, .limit, .timed_out, .data_valid
   );

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
      end
   endtask

   function automatic bit exp_to(input int lim);
      return (lim != 0) && (m_cnt >= lim);
   endfunction

   task automatic compare(input string req);
      chk({req, " timed_out"}, timed_out, exp_to(int'(limit)));
      chk({req, " data_valid"}, data_valid, m_seen && !exp_to(int'(limit)));
   endtask

   // one clock of stimulus, model update, and comparison
   task automatic step(input bit ft, input bit bo, input string req);
      @(negedge clk);
      frame_tick = ft;
      burst_ok   = bo;
      @(posedge clk);
      if (!rst_n) begin
         m_cnt = 0; m_seen = 0;
      end else if (bo) begin
         m_cnt = 0; m_seen = 1;
      end else if (ft && m_cnt < 15) begin
         m_cnt++;
      end
      #1;
      compare(req);
   endtask

   // read the hidden count through timed_out by sweeping the limit (R4)
   task automatic probe(input string req);
      logic [3:0] keep;
      @(negedge clk);
      frame_tick = 0;
      burst_ok   = 0;
      keep = limit;
      for (int l = 1; l < 16; l++) begin
         limit = 4'(l);
         #0.1;
         chk({req, " R4 probe"}, timed_out, m_cnt >= l);
      end
      limit = keep;
      #0.1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R8 reset state
      limit = 4'd3;
      rst_n = 0;
      step(1, 0, "R8");
      step(0, 1, "R8");
      rst_n = 1;
      step(0, 0, "R8");
      probe("R8");

      // R1 / R4 silent frames up to the limit, then one short of it
      for (int i = 0; i < 2; i++) step(1, 0, "R1");
      probe("R1");
      step(1, 0, "R4");
      step(0, 0, "R4");
      step(0, 1, "R2");
      for (int i = 0; i < 2; i++) step(1, 0, "R4");
      step(1, 0, "R6");

      // R2 burst together with tick counts as received
      step(1, 1, "R2");
      probe("R2");
      step(1, 0, "R1");
      step(1, 1, "R2");
      probe("R2");

      // R3 saturation after twenty silent frames
      limit = 4'd15;
      for (int i = 0; i < 20; i++) step(1, 0, "R3");
      probe("R3");
      step(0, 1, "R6");

      // R5 zero limit disables
      limit = 4'd0;
      for (int i = 0; i < 18; i++) step(1, 0, "R5");
      limit = 4'd1;
      #0.1;
      compare("R4 live limit");
      limit = 4'd0;
      step(0, 1, "R5");

      // R7 power state ignored
      limit = 4'd4;
      pwr_dn = 1;
      for (int i = 0; i < 5; i++) step(1, 0, "R7");
      probe("R7");
      step(0, 1, "R7");
      pwr_dn = 0;
      for (int i = 0; i < 5; i++) step(1, 0, "R7");
      probe("R7");

      // sparse bursts keep count low
      limit = 4'd2;
      for (int i = 0; i < 12; i++) step(1, (i % 2) == 1, "R2");
      for (int i = 0; i < 6; i++) step(i % 3 == 0, 0, "R1");
      probe("R1");

      // R8 reset in the middle of a time-out
      limit = 4'd1;
      step(1, 0, "R8");
      rst_n = 0;
      step(1, 0, "R8");
      rst_n = 1;
      step(0, 0, "R8");
      probe("R8");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule